// File: doc/BRIEF.md
# Shift and Rotate Unit with Extension Buffer

This unit shifts or rotates a 16-bit word by one to four places. It keeps a 4-bit extension buffer that persists from one operation to the next. Bits pushed out of the word land in the buffer, and the buffer in turn feeds bits back in on the following operation. This lets software build long shifts across several words, or rotate through a 24-bit chain made of buffer, word and buffer.

Three operation kinds are offered:

- Arithmetic kind: a sign-extending right shift.
- Logical kind: a zero-filling right shift when the top mode bit is set, and a left shift when it is clear.
- Rotate kind: the same split by the top mode bit.

For right moves the distance is mode minus 3. For left moves it is mode plus 1.

Operations enter through a valid/ready stream. Results leave through a one-deep registered valid/ready stream. A new operation is taken only when the output slot is empty or is being drained in the same cycle. A downstream stall therefore holds off the upstream. Inputs must stay stable while `in_valid` is high and `in_ready` is low.

Top module: `ext_shift_unit`

## Requirements
- R1: After reset `ext_buf` is 0 and `out_valid` is 0.
- R2: Kind 0 (arithmetic), modes 4..7: the 20-bit value {word, buffer} is sign-extended from its bit 19 and shifted right by mode-3. The result is bits 19:4 and the new buffer is bits 3:0.
- R3: Kind 1 (logical) with mode bit 2 set: {word, buffer} is shifted right by mode-3 with zero fill. The result and buffer are split as in R2.
- R4: Kind 1 with mode bit 2 clear: {buffer, word} is shifted left by mode+1 with zero fill. The result is bits 15:0 and the new buffer is bits 19:16.
- R5: Kind 2 (rotate) with mode bit 2 set: the 24-bit chain {buffer, word, buffer} is shifted right by mode-3. The result is bits 19:4 and the new buffer is bits 3:0.
- R6: Kind 2 with mode bit 2 clear: the same chain is shifted left by mode+1. The result is bits 19:4 and the new buffer is bits 23:20.
- R7: `ext_buf` changes only in a cycle where an operation is accepted (`in_valid` and `in_ready` both high).
- R8: Kind 3, or kind 0 with a mode below 4, is illegal. Such an operation yields `out_illegal`=1 and `out_result`=0, and leaves `ext_buf` unchanged.
- R9: While `out_valid` is high and `out_ready` is low, `out_result` and `out_illegal` hold and `in_ready` is low.
- R10: An operation accepted at a clock edge is presented with `out_valid`=1 from that same edge. `ext_buf` already shows that operation's new buffer value while its result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_word | input | 16 | Source word |
| in_mode | input | 3 | Direction and distance field |
| in_kind | input | 2 | 0 arithmetic, 1 logical, 2 rotate, 3 reserved |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes result |
| out_result | output | 16 | Shifted word |
| out_illegal | output | 1 | Operation was illegal |
| ext_buf | output | 4 | Registered extension buffer |

## Verification
The assertions assume the upstream holds `in_word`, `in_mode` and `in_kind` steady while an offer is pending. They also assume `out_ready` is a clean level sampled at the clock. The bench changes inputs only at falling edges. It moves `out_ready` shortly after rising edges, either held high or drawn pseudo-randomly for back-pressure phases. It also deliberately changes a stalled offer to confirm that no state moves until the offer is accepted.

// File: rtl/ext_shift_pkg.sv
package ext_shift_pkg;
  typedef enum logic [1:0] {
    KIND_ARITH   = 2'd0,
    KIND_LOGIC   = 2'd1,
    KIND_ROTATE  = 2'd2,
    KIND_RESERVE = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/ext_shift_core.sv
// Combinational shift/rotate datapath using the current buffer value.
module ext_shift_core #(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 4,
  parameter int MODE_W = 3
) (
  input  logic [WORD_W-1:0] word,
  input  logic [EXT_W-1:0]  ebuf,
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        kind,
  output logic [WORD_W-1:0] res,
  output logic [EXT_W-1:0]  nbuf,
  output logic              illegal
);
  import ext_shift_pkg::*;

  localparam int CW     = WORD_W + EXT_W;
  localparam int RW     = WORD_W + 2 * EXT_W;
  localparam int R_BIAS = (1 << (MODE_W - 1)) - 1;

  logic              go_right;
  logic [MODE_W-1:0] amt_r;
  logic [MODE_W-1:0] amt_l;
  logic [CW-1:0]     asr_v, lsr_v, shl_v, ror_v, rol_v;
  logic [RW-1:0]     chain;
  shift_kind_e       k;

  assign k        = shift_kind_e'(kind);
  assign go_right = mode[MODE_W-1];
  assign amt_r    = mode - MODE_W'(R_BIAS);
  assign amt_l    = mode + MODE_W'(1);
  assign chain    = {ebuf, word, ebuf};

  assign asr_v = CW'($signed({word, ebuf}) >>> amt_r);
  assign lsr_v = {word, ebuf} >> amt_r;
  assign shl_v = {ebuf, word} << amt_l;
  assign ror_v = CW'(chain >> amt_r);
  assign rol_v = CW'((chain << amt_l) >> EXT_W);

  always_comb begin
    res     = '0;
    nbuf    = ebuf;
    illegal = 1'b0;
    unique case (k)
      KIND_ARITH: begin
        if (go_right) begin
          res  = asr_v[CW-1:EXT_W];
          nbuf = asr_v[EXT_W-1:0];
        end else begin
          illegal = 1'b1;
        end
      end
      KIND_LOGIC: begin
        if (go_right) begin
          res  = lsr_v[CW-1:EXT_W];
          nbuf = lsr_v[EXT_W-1:0];
        end else begin
          res  = shl_v[WORD_W-1:0];
          nbuf = shl_v[CW-1:WORD_W];
        end
      end
      KIND_ROTATE: begin
        if (go_right) begin
          res  = ror_v[CW-1:EXT_W];
          nbuf = ror_v[EXT_W-1:0];
        end else begin
          res  = rol_v[WORD_W-1:0];
          nbuf = rol_v[CW-1:WORD_W];
        end
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ext_shift_bufreg.sv
// Persistent extension buffer register.
module ext_shift_bufreg #(
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EXT_W-1:0] d,
  output logic [EXT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/ext_shift_outstage.sv
// One-deep output slot with valid/ready handshake.
module ext_shift_outstage #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] d_res,
  input  logic              d_ill,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_illegal,
  output logic              slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_result  <= d_res;
      out_illegal <= d_ill;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_shift_unit.sv
module ext_shift_unit #(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 4,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [1:0]        in_kind,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic              out_illegal,
  output logic [EXT_W-1:0]  ext_buf
);
  logic [WORD_W-1:0] core_res;
  logic [EXT_W-1:0]  core_buf;
  logic              core_ill;
  logic              accept;

  assign accept = in_valid && in_ready;

  ext_shift_core #(.WORD_W(WORD_W), .EXT_W(EXT_W), .MODE_W(MODE_W)) u_core (
    .word(in_word), .ebuf(ext_buf), .mode(in_mode), .kind(in_kind),
    .res(core_res), .nbuf(core_buf), .illegal(core_ill)
  );

  ext_shift_bufreg #(.EXT_W(EXT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(accept && !core_ill),
    .d(core_buf), .q(ext_buf)
  );

  ext_shift_outstage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take(accept),
    .d_res(core_res), .d_ill(core_ill), .out_ready(out_ready),
    .out_valid(out_valid), .out_result(out_result),
    .out_illegal(out_illegal), .slot_free(in_ready)
  );
endmodule

// File: rtl/ext_shift_chk.sv
module ext_shift_chk #(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 4,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_word,
  input logic [MODE_W-1:0] in_mode,
  input logic [1:0]        in_kind,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result,
  input logic              out_illegal,
  input logic [EXT_W-1:0]  ext_buf
);
  logic bad_op;
  assign bad_op = (in_kind == 2'd3) || (in_kind == 2'd0 && !in_mode[MODE_W-1]);

  assert_quiet_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(ext_buf));

  assert_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && bad_op) |=> (out_illegal && $stable(ext_buf) && out_result == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_shl1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind == 2'd1 && in_mode == '0)
      |=> out_result == {$past(in_word[WORD_W-2:0]), 1'b0});
endmodule

bind ext_shift_unit ext_shift_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .in_mode(in_mode), .in_kind(in_kind),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_illegal(out_illegal), .ext_buf(ext_buf)
);

// File: tb/tb_ext_shift_unit.sv
`timescale 1ns/1ps
module tb_ext_shift_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [2:0]  in_mode = '0;
  logic [1:0]  in_kind = '0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [15:0] out_result;
  logic        out_illegal;
  logic [3:0]  ext_buf;

  int checks = 0;
  int errors = 0;
  bit bp_on = 0;
  bit done = 0;
  logic [3:0] mdl_buf = '0;

  typedef struct {
    logic [15:0] res;
    logic [3:0]  nb;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  ext_shift_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_mode(in_mode), .in_kind(in_kind),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_illegal(out_illegal), .ext_buf(ext_buf)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model computed bit by bit from the requirements.
  task automatic model(input logic [15:0] w, input logic [3:0] b, input logic [2:0] m,
                       input logic [1:0] k, output exp_t e);
    logic [19:0] v;
    logic [23:0] c;
    int amt;
    e.ill = 0; e.res = '0; e.nb = b;
    amt = m[2] ? (int'(m) - 3) : (int'(m) + 1);
    if (k == 3 || (k == 0 && !m[2])) begin
      e.ill = 1; e.tag = "R8";
    end else if (k == 0) begin
      v = {w, b};
      for (int i = 0; i < amt; i++) v = {v[19], v[19:1]};
      e.res = v[19:4]; e.nb = v[3:0]; e.tag = "R2";
    end else if (k == 1 && m[2]) begin
      v = {w, b};
      for (int i = 0; i < amt; i++) v = {1'b0, v[19:1]};
      e.res = v[19:4]; e.nb = v[3:0]; e.tag = "R3";
    end else if (k == 1) begin
      v = {b, w};
      for (int i = 0; i < amt; i++) v = {v[18:0], 1'b0};
      e.res = v[15:0]; e.nb = v[19:16]; e.tag = "R4";
    end else begin
      c = {b, w, b};
      if (m[2]) begin
        for (int i = 0; i < amt; i++) c = {1'b0, c[23:1]};
        e.res = c[19:4]; e.nb = c[3:0]; e.tag = "R5";
      end else begin
        for (int i = 0; i < amt; i++) c = {c[22:0], 1'b0};
        e.res = c[19:4]; e.nb = c[23:20]; e.tag = "R6";
      end
    end
  endtask

  task automatic drive(input logic [15:0] w, input logic [2:0] m, input logic [1:0] k);
    exp_t e;
    @(negedge clk);
    in_valid = 1; in_word = w; in_mode = m; in_kind = k;
    while (!in_ready) @(negedge clk);
    model(w, mdl_buf, m, k, e);
    mdl_buf = e.nb;
    sb_q.push_back(e);
    @(negedge clk);
    in_valid = 0;
    check("R10 out_valid after accept", {31'd0, out_valid}, 32'd1);
  endtask

  // Monitor: a result leaving at the next edge is compared now.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        check("R10 unexpected result", 32'd1, 32'd0);
      end else begin
        e = sb_q.pop_front();
        check({e.tag, " result"}, {16'd0, out_result}, {16'd0, e.res});
        check({e.tag, " illegal"}, {31'd0, out_illegal}, {31'd0, e.ill});
        check({e.tag, " R10 buffer"}, {28'd0, ext_buf}, {28'd0, e.nb});
      end
    end
  end

  always @(posedge clk) begin
    #2;
    out_ready <= bp_on ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [3:0]  bsnap;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 buffer after reset", {28'd0, ext_buf}, 32'd0);
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

    // Directed corners
    drive(16'h8000, 3'd7, 2'd0);  // R2 sign fill by 4
    drive(16'h1234, 3'd4, 2'd0);  // R2 by 1
    drive(16'hFFFF, 3'd7, 2'd1);  // R3 zero fill
    drive(16'h8001, 3'd3, 2'd1);  // R4 left by 4
    drive(16'h00F0, 3'd0, 2'd1);  // R4 left by 1
    drive(16'hA5C3, 3'd6, 2'd2);  // R5
    drive(16'h5A3C, 3'd2, 2'd2);  // R6
    drive(16'hBEEF, 3'd1, 2'd0);  // R8 arith low mode
    drive(16'hBEEF, 3'd5, 2'd3);  // R8 reserved kind
    repeat (3) @(negedge clk);

    // R7: idle with changing inputs
    bsnap = ext_buf;
    for (int i = 0; i < 5; i++) begin
      in_word = 16'($urandom); in_mode = 3'($urandom); in_kind = 2'($urandom);
      @(negedge clk);
    end
    check("R7 buffer while idle", {28'd0, ext_buf}, {28'd0, bsnap});

    // R9: stall with a pending offer
    bp_on = 0;
    @(posedge clk); #2; force out_ready = 1'b0;
    drive(16'h0F0F, 3'd4, 2'd1);
    held = out_result; bsnap = ext_buf;
    @(negedge clk);
    in_valid = 1; in_word = 16'hFFFF; in_mode = 3'd7; in_kind = 2'd0;
    repeat (4) @(negedge clk);
    check("R9 in_ready low when stalled", {31'd0, in_ready}, 32'd0);
    check("R9 result held", {16'd0, out_result}, {16'd0, held});
    check("R7 buffer held under stall", {28'd0, ext_buf}, {28'd0, bsnap});
    in_valid = 0;
    @(posedge clk); #2; release out_ready;

    // Random ops, with and without back-pressure
    for (int p = 0; p < 2; p++) begin
      bp_on = (p == 1);
      for (int i = 0; i < 150; i++)
        drive(16'($urandom), 3'($urandom), 2'($urandom));
    end
    bp_on = 0;
    repeat (10) @(negedge clk);
    check("R10 queue drained", sb_q.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule